// File: doc/BRIEF.md
# Pipelined Register File Core

This block is a parameterised bank of 32-bit software-visible registers sitting behind a strobe-style request port. The requester presents a request with a write flag, a byte address and write data. A stall output for each request type acts as back-pressure: a request is taken only in a cycle where its own stall is low. While a request is stalled, the requester must hold the request, the write flag, the address and the data unchanged until it is taken. A combinational decoder turns the address into one strobe per register. Writes update the register in the next cycle and complete in the same cycle they are taken. Every register value is also driven onto a flat hardware-side output bus.

A read is answered by OR-ing together the register values, each one gated by its own strobe. Two optional retiming stages lengthen the read path. The first splits the OR tree into two registered halves. The second registers the final response. Reads can therefore take longer than writes. To keep the two acknowledges from landing in the same cycle, a small shift register holds off writes for as many cycles as the read path is longer than the write path. Responses return in request order.

Top module: `regfile_pipe_core`

## Requirements
- R1: During and right after a synchronous active-high reset, every register reads as 0 on `hw_regs`, both acknowledges are low and both stalls are low.
- R2: A write is taken in a cycle where `req`=1, `req_is_wr`=1 and `stall_wr`=0. In that same cycle `wr_ack` is 1 and `wr_err` is 0. From the next cycle, the register with index `req_addr[ADDR_W-1:2]` holds `req_wdata` on `hw_regs` bits `[index*32 +: 32]`.
- R3: A write presented while `stall_wr`=1 is not taken. `wr_ack` stays 0 and no register changes.
- R4: A read (`req`=1, `req_is_wr`=0) is taken in any cycle, because `stall_rd` is always 0. `rd_ack` pulses exactly L cycles later, where L = FANIN_STAGE + RESP_STAGE (2 by default). It carries the addressed register's value as of the cycle the read was taken, with `rd_err`=0.
- R5: An address whose index is NUM_REGS or more selects no register. A read of it returns data 0 with `rd_err`=0. A write to it still acknowledges but changes no register.
- R6: When L>0, `stall_wr` is 1 in each of the L cycles after a taken read. With no read in the last L cycles it is 0. When L=0, `stall_wr` is always 0.
- R7: `rd_ack` and `wr_ack` are never high in the same cycle, and read responses return in request order.
- R8: `rd_data` is 0 in every cycle where `rd_ack` is 0.
- R9: Address bits [1:0] do not affect which register is selected, and `req_wdata` has no effect on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request present |
| req_is_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| stall_rd | output | 1 | Holds off a pending read |
| stall_wr | output | 1 | Holds off a pending write |
| rd_ack | output | 1 | Read response strobe |
| rd_err | output | 1 | Read error flag |
| rd_data | output | DATA_W | Read response data |
| wr_ack | output | 1 | Write response strobe |
| wr_err | output | 1 | Write error flag |
| hw_regs | output | NUM_REGS*DATA_W | All register values, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The assertions assume that `req` is low while reset is held. They also assume that a stalled write is not replaced by a different request before it is taken, so each acknowledge can be traced back to the acceptance that caused it. The stimulus keeps `req` low through reset. It holds every stalled write until the model's stall prediction clears, and then moves on. Reads, writes, idle cycles, unmapped addresses and addresses with non-zero low bits are mixed so that the write stall arises often.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  function automatic int calc_rd_lat(input int fanin_stage, input int resp_stage);
    return ((fanin_stage != 0) ? 1 : 0) + ((resp_stage != 0) ? 1 : 0);
  endfunction
endpackage

// File: rtl/regfile_decode.sv
module regfile_decode #(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 8
) (
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] strobe
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (take && (int'(idx) == i)) strobe[i] = 1'b1;
    end
  end
endmodule

// File: rtl/regfile_storage.sv
module regfile_storage #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_REGS-1:0]        wr_strobe,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] values
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) values[g*DATA_W +: DATA_W] <= '0;
      else if (wr_strobe[g]) values[g*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/regfile_readback.sv
module regfile_readback #(
  parameter int NUM_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int FANIN_STAGE = 1,
  parameter int RESP_STAGE  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_take,
  input  logic [NUM_REGS-1:0]        rd_strobe,
  input  logic [NUM_REGS*DATA_W-1:0] values,
  output logic                       ack,
  output logic [DATA_W-1:0]          data
);
  localparam int HALF = (NUM_REGS + 1) / 2;

  logic              mid_vld;
  logic [DATA_W-1:0] mid_data;

  if (FANIN_STAGE != 0) begin : g_fanin
    logic [DATA_W-1:0] part_lo, part_hi, q_lo, q_hi;
    logic              q_vld;
    always_comb begin
      part_lo = '0;
      part_hi = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (i < HALF) part_lo |= values[i*DATA_W +: DATA_W] & {DATA_W{rd_strobe[i]}};
        else          part_hi |= values[i*DATA_W +: DATA_W] & {DATA_W{rd_strobe[i]}};
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        q_lo  <= '0;
        q_hi  <= '0;
        q_vld <= 1'b0;
      end else begin
        q_lo  <= part_lo;
        q_hi  <= part_hi;
        q_vld <= rd_take;
      end
    end
    assign mid_data = q_lo | q_hi;
    assign mid_vld  = q_vld;
  end else begin : g_flat
    always_comb begin
      mid_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
        mid_data |= values[i*DATA_W +: DATA_W] & {DATA_W{rd_strobe[i]}};
    end
    assign mid_vld = rd_take;
  end

  if (RESP_STAGE != 0) begin : g_resp
    always_ff @(posedge clk) begin
      if (rst) begin
        ack  <= 1'b0;
        data <= '0;
      end else begin
        ack  <= mid_vld;
        data <= mid_data;
      end
    end
  end else begin : g_noresp
    assign ack  = mid_vld;
    assign data = mid_data;
  end
endmodule

// File: rtl/regfile_stall.sv
module regfile_stall #(
  parameter int LAT_DIFF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_take,
  output logic stall_wr
);
  if (LAT_DIFF == 0) begin : g_none
    assign stall_wr = 1'b0;
  end else begin : g_sr
    logic [LAT_DIFF-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst)          sr <= '0;
      else if (rd_take) sr <= '1;
      else              sr <= sr >> 1;
    end
    assign stall_wr = sr[0];
  end
endmodule

// File: rtl/regfile_pipe_core.sv
module regfile_pipe_core
  import regfile_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int FANIN_STAGE = 1,
  parameter int RESP_STAGE  = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic                       req_is_wr,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       stall_rd,
  output logic                       stall_wr,
  output logic                       rd_ack,
  output logic                       rd_err,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       wr_ack,
  output logic                       wr_err,
  output logic [NUM_REGS*DATA_W-1:0] hw_regs
);
  localparam int RD_LAT = calc_rd_lat(FANIN_STAGE, RESP_STAGE);
  localparam int WR_LAT = 0;

  logic                take, wr_take, rd_take;
  logic [NUM_REGS-1:0] strobe;

  assign take    = req && !(req_is_wr ? stall_wr : stall_rd);
  assign wr_take = take && req_is_wr;
  assign rd_take = take && !req_is_wr;

  regfile_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .take(take), .addr(req_addr), .strobe(strobe)
  );

  regfile_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_strobe(strobe & {NUM_REGS{req_is_wr}}),
    .wdata(req_wdata), .values(hw_regs)
  );

  regfile_readback #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
                     .FANIN_STAGE(FANIN_STAGE), .RESP_STAGE(RESP_STAGE)) u_rb (
    .clk(clk), .rst(rst), .rd_take(rd_take),
    .rd_strobe(strobe & {NUM_REGS{!req_is_wr}}),
    .values(hw_regs), .ack(rd_ack), .data(rd_data)
  );

  regfile_stall #(.LAT_DIFF(RD_LAT - WR_LAT)) u_stall (
    .clk(clk), .rst(rst), .rd_take(rd_take), .stall_wr(stall_wr)
  );

  assign stall_rd = 1'b0;
  assign rd_err   = 1'b0;
  assign wr_ack   = wr_take;
  assign wr_err   = 1'b0;
endmodule

// File: rtl/regfile_pipe_core_chk.sv
module regfile_pipe_core_chk
  import regfile_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int FANIN_STAGE = 1,
  parameter int RESP_STAGE  = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req,
  input logic                       req_is_wr,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [DATA_W-1:0]          req_wdata,
  input logic                       stall_rd,
  input logic                       stall_wr,
  input logic                       rd_ack,
  input logic                       rd_err,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       wr_ack,
  input logic                       wr_err,
  input logic [NUM_REGS*DATA_W-1:0] hw_regs
);
  localparam int LAT = calc_rd_lat(FANIN_STAGE, RESP_STAGE);

  logic rd_seen;
  assign rd_seen = req && !req_is_wr && !stall_rd;

  logic              wr_hit_q;
  int                idx_q;
  logic [DATA_W-1:0] wd_q;
  always_ff @(posedge clk) begin
    wr_hit_q <= wr_ack && (int'(req_addr >> 2) < NUM_REGS);
    idx_q    <= int'(req_addr >> 2);
    wd_q     <= req_wdata;
  end

  assert_wr_taken_R2: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (req && req_is_wr && !stall_wr));

  assert_stalled_wr_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (req && req_is_wr && stall_wr) |-> !wr_ack);

  assert_store_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit_q |-> (hw_regs[idx_q*DATA_W +: DATA_W] == wd_q));

  assert_one_ack_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd_ack && wr_ack));

  assert_idle_data_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |-> (rd_data == '0));

  if (LAT > 0) begin : g_lat
    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
      rd_ack == $past(rd_seen, LAT));
    assert_stall_after_rd_R6: assert property (@(posedge clk) disable iff (rst)
      rd_seen |=> stall_wr);
  end else begin : g_nolat
    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
      rd_ack == rd_seen);
    assert_stall_low_R6: assert property (@(posedge clk) disable iff (rst)
      !stall_wr);
  end
endmodule

bind regfile_pipe_core regfile_pipe_core_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .FANIN_STAGE(FANIN_STAGE), .RESP_STAGE(RESP_STAGE)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .req_is_wr(req_is_wr), .req_addr(req_addr),
  .req_wdata(req_wdata), .stall_rd(stall_rd), .stall_wr(stall_wr),
  .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data), .wr_ack(wr_ack),
  .wr_err(wr_err), .hw_regs(hw_regs)
);

// File: tb/tb_regfile_pipe_core.sv
`timescale 1ns/1ps
module tb_regfile_pipe_core;
  localparam int NR  = 16;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst;
  logic req, req_is_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic stall_rd, stall_wr, rd_ack, rd_err, wr_ack, wr_err;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] hw_regs;

  always #5 clk = ~clk;

  regfile_pipe_core #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW),
                      .FANIN_STAGE(1), .RESP_STAGE(1)) dut (
    .clk(clk), .rst(rst), .req(req), .req_is_wr(req_is_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .stall_rd(stall_rd), .stall_wr(stall_wr),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data), .wr_ack(wr_ack),
    .wr_err(wr_err), .hw_regs(hw_regs)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stall_cnt = 0;
  logic [DW-1:0] mregs [NR];
  int            due_q[$];
  logic [DW-1:0] dat_q[$];

  task automatic chk(input string tag, input string what, input logic [NR*DW-1:0] act,
                     input logic [NR*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NR*DW-1:0] model_vec();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = mregs[i];
    return v;
  endfunction

  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output bit acc);
    bit exp_stall, exp_wack, exp_rack;
    logic [DW-1:0] exp_rdata;
    int idx;
    @(negedge clk);
    req = v; req_is_wr = w; req_addr = a; req_wdata = d;
    #1;
    exp_stall = (stall_cnt > 0);
    acc = v && !(w && exp_stall);
    exp_wack = acc && w;
    exp_rack = (due_q.size() > 0) && (due_q[0] == cyc);
    exp_rdata = exp_rack ? dat_q[0] : '0;
    chk("R6", "stall_wr", {511'b0, stall_wr}, {511'b0, exp_stall});
    chk("R4", "stall_rd", {511'b0, stall_rd}, '0);
    chk(w && exp_stall ? "R3" : "R2", "wr_ack", {511'b0, wr_ack}, {511'b0, exp_wack});
    chk("R2", "wr_err", {511'b0, wr_err}, '0);
    chk("R7", "rd_ack", {511'b0, rd_ack}, {511'b0, exp_rack});
    chk("R5", "rd_err", {511'b0, rd_err}, '0);
    chk(exp_rack ? "R4" : "R8", "rd_data", {480'b0, rd_data}, {480'b0, exp_rdata});
    chk("R3", "hw_regs", hw_regs, model_vec());
    if (exp_rack) begin
      void'(due_q.pop_front());
      void'(dat_q.pop_front());
    end
    idx = int'(a[AW-1:2]);
    if (acc && !w) begin
      due_q.push_back(cyc + LAT);
      dat_q.push_back(idx < NR ? mregs[idx] : '0);
    end
    if (acc && w && idx < NR) mregs[idx] = d;
    if (acc && !w) stall_cnt = LAT;
    else if (stall_cnt > 0) stall_cnt--;
    cyc++;
  endtask

  task automatic op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit acc;
    do step(1'b1, w, a, d, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, acc);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) mregs[i] = '0;
    rst = 1'b1; req = 1'b0; req_is_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "hw_regs reset", hw_regs, '0);
    chk("R1", "acks reset", {510'b0, rd_ack, wr_ack}, '0);
    chk("R1", "stalls reset", {510'b0, stall_rd, stall_wr}, '0);

    // R2: back-to-back writes to every register
    for (int i = 0; i < NR; i++) op(1'b1, AW'(i*4), 32'h1234_0000 + i);
    idle(2);
    // R4 R7: pipelined reads of every register
    for (int i = 0; i < NR; i++) op(1'b0, AW'(i*4), 32'hdead_beef);
    idle(4);
    // R6 R3: write straight after read is held, then taken
    op(1'b0, 8'h08, '0);
    op(1'b1, 8'h08, 32'hcafe_0001);
    op(1'b0, 8'h08, '0);
    idle(4);
    // R5: unmapped addresses
    op(1'b1, 8'hfc, 32'hffff_ffff);
    op(1'b0, 8'hfc, '0);
    op(1'b0, 8'h40, '0);
    idle(4);
    // R9: low address bits ignored
    op(1'b1, 8'h17, 32'h5a5a_0005);
    idle(1);
    op(1'b0, 8'h15, 32'h1111_1111);
    idle(4);
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) idle(1);
      else op(r < 5, AW'($urandom_range(0, 255)), $urandom);
    end
    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule